// File: doc/BRIEF.md
# Mux-Adder-NAND Sliced ALU

This block is a purely combinational N-bit arithmetic and logic unit (default width 4) that carries no function decoder. Its operation comes straight from four select bits that steer three pieces of hardware. An operand multiplexor prepares the second operand: it passes B, passes its bitwise complement, or forces it to zero through a disable input. An adder and a bitwise NAND both combine A with that prepared operand. A result multiplexor, whose disable is held inactive, then picks one of the two outputs.

The 4-bit operation code gives sixteen codes. Some of them repeat each other and some are of little use, but together they cover A+B, A+B+1, A+~B, A-B, pass A, A+1, NAND(A,B), NAND(A,~B) and a constant of all ones. The adder carry-out is always driven, whichever result is selected. A small control module turns the code into a struct of strobes, and the datapath module holds the multiplexors, the adder and the NAND.

Top module: `mna_alu`

## Requirements
- R1: The operation code is 4 bits wide. Bit 3 selects the result (0 = NAND, 1 = sum), bit 2 disables the operand, bit 1 inverts the operand, and bit 0 is the adder carry input.
- R2: When bit 2 is 0, the prepared operand is B if bit 1 is 0 and ~B if bit 1 is 1.
- R3: When bit 2 is 1, the prepared operand is all zeros whatever bit 1 holds. With bit 3 at 1 the result is then A plus bit 0, and with bit 3 at 0 the result is all ones.
- R4: The adder forms A + prepared operand + bit 0. Its low N bits are the sum, and bit N is the carry-out.
- R5: With bit 3 at 0, the result is the bitwise NAND of A and the prepared operand.
- R6: With bit 3 at 1, the result is the adder sum. Code 4'b1100 returns A unchanged with a carry-out of 0.
- R7: The carry-out is the adder carry for every code, including codes that select the NAND result.
- R8: Code 4'b1011 returns A-B modulo 2^N, with a carry-out of 1 exactly when A >= B (unsigned).
- R9: The outputs depend only on the present inputs. There is no internal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand, before preparation |
| opCode | input | 4 | Operation code: result select, operand disable, operand invert, carry in |
| result | output | WIDTH | Selected NAND or sum output |
| carryOut | output | 1 | Adder carry-out, always driven |

## Verification
The block holds no state, so any fault in the operand preparation or in the result steering shows on `result` or `carryOut` within the same evaluation as the input change. A wrong invert or disable path corrupts the sum and the NAND for every code that shares that setting. A swapped result select flips whole groups of eight codes. A carry that is gated by the result select only shows up on the NAND codes. Because every code is swept over every operand pair, the first wrong code/operand combination is reported directly.

// File: rtl/mna_alu_pkg.sv
package mna_alu_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic pickSum;   // result mux select
    logic opDis;     // operand mux disable
    logic opInv;     // operand mux select (complement)
    logic carryIn;   // adder carry input
  } aluStrobes_t;

  localparam int CODE_W = 4;
endpackage

// File: rtl/mna_gate_mux.sv
module mna_gate_mux #(
  parameter int WIDTH = 4
) (
  input  logic             selIn,
  input  logic             disIn,
  input  logic [WIDTH-1:0] in0,
  input  logic [WIDTH-1:0] in1,
  output logic [WIDTH-1:0] muxOut
);
  always_comb begin
    if (disIn) muxOut = '0;
    else       muxOut = selIn ? in1 : in0;
  end
endmodule

// File: rtl/mna_alu_ctrl.sv
module mna_alu_ctrl
  import mna_alu_pkg::*;
(
  input  logic [CODE_W-1:0] opCode,
  output aluStrobes_t       strobes
);
  // R1: fixed bit order of the code, most significant first
  always_comb begin
    strobes.pickSum = opCode[3];
    strobes.opDis   = opCode[2];
    strobes.opInv   = opCode[1];
    strobes.carryIn = opCode[0];
  end
endmodule

// File: rtl/mna_alu_dp.sv
module mna_alu_dp
  import mna_alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);
  localparam int SUM_W = WIDTH + 1;

  logic [WIDTH-1:0] prepB;
  logic [WIDTH-1:0] nandOut;
  logic [SUM_W-1:0] total;

  mna_gate_mux #(.WIDTH(WIDTH)) operandMux (
    .selIn (strobes.opInv),
    .disIn (strobes.opDis),
    .in0   (opB),
    .in1   (~opB),
    .muxOut(prepB)
  );

  always_comb begin
    total   = {1'b0, opA} + {1'b0, prepB} + {{WIDTH{1'b0}}, strobes.carryIn};
    nandOut = ~(opA & prepB);
  end

  mna_gate_mux #(.WIDTH(WIDTH)) resultMux (
    .selIn (strobes.pickSum),
    .disIn (1'b0),
    .in0   (nandOut),
    .in1   (total[WIDTH-1:0]),
    .muxOut(result)
  );

  assign carryOut = total[WIDTH];

  // Assertions beside the datapath they guard
  always_comb begin
    if (strobes.opDis && !strobes.pickSum)
      assert_nand_ones_R3: assert (result == {WIDTH{1'b1}})
        else $error("disabled operand NAND not all ones");
    if (strobes.opDis)
      assert_dis_sum_R3: assert (total == ({1'b0, opA} + {{WIDTH{1'b0}}, strobes.carryIn}))
        else $error("disabled operand did not reach adder as zero");
    if (strobes.opDis && !strobes.carryIn && strobes.pickSum)
      assert_pass_R6: assert (result == opA && !carryOut)
        else $error("pass code wrong");
    if (!strobes.opDis && strobes.opInv && strobes.carryIn && strobes.pickSum)
      assert_sub_R8: assert (result == opA - opB && carryOut == (opA >= opB))
        else $error("subtract code wrong");
  end
endmodule

// File: rtl/mna_alu.sv
module mna_alu
  import mna_alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic [CODE_W-1:0] opCode,
  output logic [WIDTH-1:0]  result,
  output logic              carryOut
);
  aluStrobes_t strobes;

  mna_alu_ctrl ctrl_i (
    .opCode (opCode),
    .strobes(strobes)
  );

  mna_alu_dp #(.WIDTH(WIDTH)) dp_i (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result),
    .carryOut(carryOut)
  );
endmodule

// File: tb/mna_alu_tb.sv
module mna_alu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int SPAN = 1 << W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [3:0]   opCode = '0;
  logic [W-1:0] result;
  logic         carryOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mna_alu #(.WIDTH(W)) dut_i (
    .opA(opA), .opB(opB), .opCode(opCode),
    .result(result), .carryOut(carryOut)
  );

  task automatic apply(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
    @(posedge clk);
    opCode = c; opA = a; opB = b;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s code=%b a=%0d b=%0d actual=%0h expected=%0h", req, opCode, opA, opB, act, exp);
    end
  endtask

  // R9: with inputs at rest after reset, code 0 gives NAND(0,0) and no carry
  task automatic testRestState();
    apply(4'b0000, '0, '0);
    check("R9", {carryOut, result}, {1'b0, {W{1'b1}}});
  endtask

  // R1 R2 R4 R6 R7: every code against an arithmetic reference for every operand pair
  task automatic testAllCodes();
    for (int c = 0; c < 16; c++)
      for (int a = 0; a < SPAN; a++)
        for (int b = 0; b < SPAN; b++) begin
          logic [W-1:0] pb;
          logic [W:0]   s;
          logic [W-1:0] expR;
          pb = c[2] ? '0 : (c[1] ? W'(~b) : W'(b));
          s = (W+1)'(a) + (W+1)'(pb) + (W+1)'(c[0]);
          expR = c[3] ? s[W-1:0] : W'(~(a & pb));
          apply(c[3:0], W'(a), W'(b));
          check(c[3] ? "R6" : "R5", {1'b0, result}, {1'b0, expR});
          check("R7", {{W{1'b0}}, carryOut}, {{W{1'b0}}, s[W]});
        end
  endtask

  // R8: subtract code
  task automatic testSubtract();
    for (int a = 0; a < SPAN; a++)
      for (int b = 0; b < SPAN; b++) begin
        apply(4'b1011, W'(a), W'(b));
        check("R8", {carryOut, result}, {(a >= b) ? 1'b1 : 1'b0, W'(a - b)});
      end
  endtask

  // R3: disabled operand, invert bit ignored; R6 pass code
  task automatic testDisabled();
    for (int a = 0; a < SPAN; a++) begin
      apply(4'b1100, W'(a), W'(SPAN-1));
      check("R6", {carryOut, result}, {1'b0, W'(a)});
      apply(4'b1110, W'(a), W'(5));
      check("R3", {carryOut, result}, {1'b0, W'(a)});
      apply(4'b1101, W'(a), W'(3));
      check("R3", {carryOut, result}, (W+1)'(a + 1));
      apply(4'b0110, W'(a), W'(a));
      check("R3", {1'b0, result}, {1'b0, {W{1'b1}}});
    end
  endtask

  // R2: complement against B, R7 carry on NAND codes
  task automatic testInvertAndCarry();
    apply(4'b0010, {W{1'b1}}, '0);
    check("R2", {1'b0, result}, {1'b0, W'(0)});
    apply(4'b0000, {W{1'b1}}, '0);
    check("R2", {1'b0, result}, {1'b0, {W{1'b1}}});
    apply(4'b0001, {W{1'b1}}, W'(1));
    check("R7", {{W{1'b0}}, carryOut}, (W+1)'(1));
    apply(4'b1000, W'(9), W'(8));
    check("R4", {carryOut, result}, (W+1)'(17));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    testRestState();
    testAllCodes();
    testSubtract();
    testDisabled();
    testInvertAndCarry();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule